// File: doc/BRIEF.md
# Stop-Grant Clock Throttle Handshake

This block drives an active-low stop-clock line to a processor and watches the host bus for the processor's reply. A single internal request input asks for the clock to be stopped. While that request is high the block holds the stop-clock line low. It also checks every bus cycle that the bus monitor presents, looking for the stop-grant acknowledgement.

A configuration input chooses how an acknowledgement is recognised. The first rule tests one address bit of a special cycle. The second rule tests the whole data word of a special cycle against a fixed value. A second configuration input makes the block keep the clock stopped after the request has ended, until an acknowledgement has been seen. This rule applies whatever caused the line to go low. Four states sequence the handshake: idle, asserted, waiting for grant, and a single release cycle. The current state and a grant-received flag are visible on the outputs.

Top module: `stopgrant_throttle`

## Requirements
- R1: While reset is high and in the first cycle after it, stop_clk_n is 1, seq_state is 0 (idle) and grant_seen is 0.
- R2: When stop_req is 1 in the idle state, stop_clk_n is 0 and seq_state is 1 (asserted) in the next cycle.
- R3: When grant_by_data is 0, a cycle matches as a stop-grant when bus_valid and bus_special are 1 and bit 4 of bus_addr is 1. bus_data is not looked at.
- R4: When grant_by_data is 1, a cycle matches when bus_valid and bus_special are 1 and bus_data equals 32'h0012_0002. bus_addr is not looked at. A cycle with bus_special at 0 never matches, in either mode.
- R5: When hold_for_grant is 0 and stop_req falls in the asserted state, the next cycle is the release state (seq_state 3) with stop_clk_n at 1.
- R6: When hold_for_grant is 1, stop_req falls in the asserted state and no grant has been seen, the block enters the wait state (seq_state 2) with stop_clk_n kept at 0. A matching cycle in the wait state moves it to the release state in the next cycle.
- R7: When hold_for_grant is 1 and a grant was already seen while asserted, a fall of stop_req goes straight to the release state.
- R8: grant_seen becomes 1 in the cycle after a matching cycle that arrives while stop_clk_n is 0. It is 0 whenever stop_clk_n is 1.
- R9: A matching cycle that arrives while stop_clk_n is 1 is ignored. grant_seen stays 0, and a later request with hold_for_grant at 1 still waits.
- R10: If stop_req rises again in the wait state, the block returns to the asserted state and keeps stop_clk_n at 0.
- R11: If hold_for_grant is cleared in the wait state, the block moves to the release state in the next cycle.
- R12: The release state lasts exactly one cycle and is followed by the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Internal stop-clock request |
| hold_for_grant | input | 1 | 1 = keep the clock stopped until a grant is seen |
| grant_by_data | input | 1 | Decode rule select: 0 = address bit 4, 1 = data word |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_special | input | 1 | The presented cycle is a special cycle |
| bus_addr | input | 32 | Address-phase word of the cycle |
| bus_data | input | 32 | Data-phase word of the cycle |
| stop_clk_n | output | 1 | Active-low stop-clock to the processor |
| grant_seen | output | 1 | A stop-grant was received during the current stop |
| seq_state | output | 2 | Handshake state: 0 idle, 1 asserted, 2 wait, 3 release |

## Verification
The assertions assume that the configuration inputs and the bus-cycle fields are stable for a whole clock and change only between edges. They also assume that a bus cycle lasts one clock, so a single valid strobe is one decoded cycle. The stimulus changes every input just after a rising edge and holds bus_valid high for one clock per cycle. It changes hold_for_grant only while the block is idle, except in the one scenario that clears it on purpose in the wait state.

// File: rtl/stopgrant_pkg.sv
package stopgrant_pkg;

    localparam int unsigned BUS_ADDR_W    = 32;
    localparam int unsigned BUS_DATA_W    = 32;
    localparam int unsigned GRANT_ADDR_IX = 4;
    localparam logic [BUS_DATA_W-1:0] GRANT_WORD = 32'h0012_0002;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_ASSERTED = 2'd1,
        SEQ_WAIT     = 2'd2,
        SEQ_RELEASE  = 2'd3
    } seq_state_e;

    typedef enum logic {
        DEC_ADDR_BIT = 1'b0,
        DEC_DATA_WORD = 1'b1
    } dec_rule_e;

    typedef struct packed {
        logic                  valid;
        logic                  special;
        logic [BUS_ADDR_W-1:0] addr;
        logic [BUS_DATA_W-1:0] data;
    } bus_cycle_t;

    function automatic logic clock_held(input seq_state_e s);
        return (s == SEQ_ASSERTED) || (s == SEQ_WAIT);
    endfunction

endpackage

// File: rtl/stopgrant_decoder.sv
module stopgrant_decoder
    import stopgrant_pkg::*;
#(
    parameter int unsigned ADDR_W = BUS_ADDR_W,
    parameter int unsigned DATA_W = BUS_DATA_W,
    parameter int unsigned ADDR_IX = GRANT_ADDR_IX,
    parameter logic [DATA_W-1:0] MATCH_WORD = GRANT_WORD
) (
    input  logic              special_ok,
    input  dec_rule_e         rule,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit
);
    logic by_addr;
    logic by_data;

    assign by_addr = addr[ADDR_IX];
    assign by_data = (data == MATCH_WORD);

    always_comb begin
        unique case (rule)
            DEC_ADDR_BIT:  hit = special_ok & by_addr;
            DEC_DATA_WORD: hit = special_ok & by_data;
            default:       hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/stopgrant_seq.sv
module stopgrant_seq
    import stopgrant_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       hold,
    input  logic       hit,
    input  logic       granted,
    output seq_state_e state_q,
    output seq_state_e state_d
);
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (req) state_d = SEQ_ASSERTED;
            end
            SEQ_ASSERTED: begin
                if (!req) begin
                    if (!hold || granted || hit) state_d = SEQ_RELEASE;
                    else                         state_d = SEQ_WAIT;
                end
            end
            SEQ_WAIT: begin
                if (req)               state_d = SEQ_ASSERTED;
                else if (hit || !hold) state_d = SEQ_RELEASE;
            end
            SEQ_RELEASE: state_d = SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/stopgrant_flag.sv
module stopgrant_flag
    import stopgrant_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_q,
    input  seq_state_e state_d,
    input  logic       hit,
    output logic       granted
);
    logic granted_d;

    always_comb begin
        if (clock_held(state_d))
            granted_d = granted | (clock_held(state_q) & hit);
        else
            granted_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) granted <= 1'b0;
        else     granted <= granted_d;
    end
endmodule

// File: rtl/stopgrant_throttle.sv
module stopgrant_throttle
    import stopgrant_pkg::*;
#(
    parameter int unsigned ADDR_W = BUS_ADDR_W,
    parameter int unsigned DATA_W = BUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req,
    input  logic              hold_for_grant,
    input  logic              grant_by_data,
    input  logic              bus_valid,
    input  logic              bus_special,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              stop_clk_n,
    output logic              grant_seen,
    output logic [1:0]        seq_state
);
    seq_state_e st_q;
    seq_state_e st_d;
    logic       sg_hit;
    logic       grant_q;
    dec_rule_e  rule;

    assign rule = dec_rule_e'(grant_by_data);

    stopgrant_decoder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) dec_i (
        .special_ok (bus_valid & bus_special),
        .rule       (rule),
        .addr       (bus_addr),
        .data       (bus_data),
        .hit        (sg_hit)
    );

    stopgrant_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .req     (stop_req),
        .hold    (hold_for_grant),
        .hit     (sg_hit),
        .granted (grant_q),
        .state_q (st_q),
        .state_d (st_d)
    );

    stopgrant_flag flag_i (
        .clk     (clk),
        .rst     (rst),
        .state_q (st_q),
        .state_d (st_d),
        .hit     (sg_hit),
        .granted (grant_q)
    );

    assign stop_clk_n = ~clock_held(st_q);
    assign grant_seen = grant_q;
    assign seq_state  = st_q;
endmodule

// File: rtl/stopgrant_throttle_chk.sv
module stopgrant_throttle_chk
    import stopgrant_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stop_req,
    input logic       hold_for_grant,
    input logic       sg_hit,
    input logic       stop_clk_n,
    input logic       grant_seen,
    input logic [1:0] seq_state
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (stop_clk_n && seq_state == 2'd0 && !grant_seen));

    assert_req_asserts_R2: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd0 && stop_req) |=> (!stop_clk_n && seq_state == 2'd1));

    assert_no_hold_release_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd1 && !stop_req && !hold_for_grant) |=> (stop_clk_n && seq_state == 2'd3));

    assert_hold_waits_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd1 && !stop_req && hold_for_grant && !grant_seen && !sg_hit)
        |=> (!stop_clk_n && seq_state == 2'd2));

    assert_wait_grant_release_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd2 && !stop_req && sg_hit) |=> (seq_state == 2'd3));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        stop_clk_n |-> !grant_seen);

    assert_ignore_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (stop_clk_n && !stop_req) |=> !grant_seen);

    assert_rereq_R10: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd2 && stop_req) |=> (seq_state == 2'd1));

    assert_release_once_R12: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd3) |=> (seq_state == 2'd0));
endmodule

bind stopgrant_throttle stopgrant_throttle_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .stop_req       (stop_req),
    .hold_for_grant (hold_for_grant),
    .sg_hit         (sg_hit),
    .stop_clk_n     (stop_clk_n),
    .grant_seen     (grant_seen),
    .seq_state      (seq_state)
);

// File: tb/stopgrant_throttle_tb.sv
module stopgrant_throttle_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop_req = 1'b0;
    logic        hold_for_grant = 1'b0;
    logic        grant_by_data = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_special = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        stop_clk_n;
    logic        grant_seen;
    logic [1:0]  seq_state;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    stopgrant_throttle dut_i (
        .clk            (clk),
        .rst            (rst),
        .stop_req       (stop_req),
        .hold_for_grant (hold_for_grant),
        .grant_by_data  (grant_by_data),
        .bus_valid      (bus_valid),
        .bus_special    (bus_special),
        .bus_addr       (bus_addr),
        .bus_data       (bus_data),
        .stop_clk_n     (stop_clk_n),
        .grant_seen     (grant_seen),
        .seq_state      (seq_state)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic clk_n, input logic [1:0] st, input logic g);
        check({tag, " stop_clk_n"}, {31'd0, stop_clk_n}, {31'd0, clk_n});
        check({tag, " seq_state"}, {30'd0, seq_state}, {30'd0, st});
        check({tag, " grant_seen"}, {31'd0, grant_seen}, {31'd0, g});
    endtask

    // one-clock bus cycle
    task automatic bus_cycle(input logic sp, input logic [31:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_special = sp; bus_addr = a; bus_data = d;
        step();
        bus_valid = 1'b0; bus_special = 1'b0; bus_addr = '0; bus_data = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        expect_out("R1 in reset", 1'b1, 2'd0, 1'b0);
        rst = 1'b0;
        step();
        expect_out("R1 after reset", 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_no_hold();
        hold_for_grant = 1'b0;
        stop_req = 1'b1;
        step();
        expect_out("R2 assert", 1'b0, 2'd1, 1'b0);
        stop_req = 1'b0;
        step();
        expect_out("R5 release", 1'b1, 2'd3, 1'b0);
        step();
        expect_out("R12 back to idle", 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_addr_rule();
        hold_for_grant = 1'b1; grant_by_data = 1'b0;
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        step();
        expect_out("R6 wait entered", 1'b0, 2'd2, 1'b0);
        bus_cycle(1'b0, 32'h0000_0010, 32'h0012_0002);
        expect_out("R4 non-special ignored", 1'b0, 2'd2, 1'b0);
        bus_cycle(1'b1, 32'hFFFF_FFEF, 32'h0012_0002);
        expect_out("R3 addr bit4 clear no match", 1'b0, 2'd2, 1'b0);
        bus_cycle(1'b1, 32'h0000_0010, 32'h0);
        expect_out("R3 R6 grant releases", 1'b1, 2'd3, 1'b0);
        step();
        expect_out("R12 idle after release", 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_data_rule();
        hold_for_grant = 1'b1; grant_by_data = 1'b1;
        stop_req = 1'b1;
        step();
        bus_cycle(1'b1, 32'h0000_0010, 32'h0012_0003);
        expect_out("R4 addr bit ignored wrong data", 1'b0, 2'd1, 1'b0);
        bus_cycle(1'b1, 32'h0, 32'h0012_0002);
        expect_out("R8 R4 grant flag set", 1'b0, 2'd1, 1'b1);
        stop_req = 1'b0;
        step();
        expect_out("R7 R8 direct release flag cleared", 1'b1, 2'd3, 1'b0);
        step();
        grant_by_data = 1'b0;
    endtask

    task automatic t_ignore_idle();
        hold_for_grant = 1'b1;
        bus_cycle(1'b1, 32'h0000_0010, 32'h0);
        expect_out("R9 grant while idle ignored", 1'b1, 2'd0, 1'b0);
        stop_req = 1'b1;
        step();
        expect_out("R9 no stale flag", 1'b0, 2'd1, 1'b0);
        stop_req = 1'b0;
        step();
        expect_out("R9 still waits", 1'b0, 2'd2, 1'b0);
    endtask

    task automatic t_rereq_and_unhold();
        stop_req = 1'b1;
        step();
        expect_out("R10 back to asserted", 1'b0, 2'd1, 1'b0);
        stop_req = 1'b0;
        step();
        expect_out("R10 wait again", 1'b0, 2'd2, 1'b0);
        hold_for_grant = 1'b0;
        step();
        expect_out("R11 hold cleared releases", 1'b1, 2'd3, 1'b0);
        step();
        expect_out("R12 idle", 1'b1, 2'd0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_no_hold();
        t_addr_rule();
        t_data_rule();
        t_ignore_idle();
        t_rereq_and_unhold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule